// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `W` bits each (8 by default) and gives a product of `2W` bits. It uses one adder and a product register of double width. While the block is idle it holds `done` high. A one-cycle pulse, or any longer high level, on `go` starts an operation. The next cycle captures both operands and clears the product. After that, each cycle consumes one multiplier bit, starting with the least significant.

On each multiply cycle, the upper half of the product has either the multiplicand or zero added to it. The sum is one bit wider than the half, because it keeps the carry. That sum is written back one position lower, and the lower half shifts right with it. After `W` such cycles the register holds the full product, and `done` returns high. The product then stays on `prod` until the next start.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 1 and `prod` is 0.
- R2: `done` is 1 whenever the block is idle. The block stays idle until it samples `go` = 1 on a rising clock edge.
- R3: After the edge that samples `go` = 1 while idle, `done` is 0 for exactly `W`+1 cycles. It then returns to 1, so `done` rises on the `W`+1th edge after the start edge.
- R4: One cycle after `done` falls, `prod` is 0.
- R5: After k multiply cycles (1 ≤ k ≤ `W`), `prod` equals (A × (B mod 2^k)) × 2^(W−k). Here A and B are the captured multiplicand and multiplier.
- R6: When `done` rises, `prod` equals A × B as a full `2W`-bit value. The top bit is kept, for example 255 × 255 = 65025.
- R7: Operands are captured on the edge one cycle after the start edge. Changes to `mcand` and `mplier` after that edge do not affect the result.
- R8: Holding `go` at 1 during an operation does not change its timing or its result.
- R9: While idle with `go` = 0, `prod` holds its value whatever `mcand` and `mplier` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request, sampled while idle |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| done | output | 1 | High while idle; the product is valid |
| prod | output | 2W | Product register |

## Verification
The operand pairs cover the following cases:
- **All-ones by all-ones:** proves that the carry of each partial sum lands in the top product bit.
- **Zero and one cases:** operands with zero or one on either side separate the add path from the add-zero path.
- **Alternating bit patterns and a single high bit:** show whether bits are consumed in the right order and shifted by the right amount.

Random pairs then cover the general case. The partial product is compared after every multiply cycle, so a wrong shift or a wrong step count shows up at once, not only at the end.

Operands are scrambled right after capture, and `go` is held high through one whole operation. These two cases separate correct sampling from a design that reads its inputs late or restarts.

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);
  localparam logic [2:0] S_IDLE = 3'b100;
  localparam logic [2:0] S_LOAD = 3'b010;
  localparam logic [2:0] S_STEP = 3'b001;

  logic [2:0]    st;
  logic [CW-1:0] left;
  logic [W-1:0]  mc_q;
  logic [W-1:0]  mp_sr;
  logic [W-1:0]  addend;
  logic [W:0]    sum;

  assign addend = mp_sr[0] ? mc_q : '0;
  assign sum    = {1'b0, prod[2*W-1:W]} + {1'b0, addend};
  assign done   = st[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      prod  <= '0;
      left  <= '0;
      mc_q  <= '0;
      mp_sr <= '0;
    end else if (st[2]) begin
      if (go) st <= S_LOAD;
    end else if (st[1]) begin
      prod  <= '0;
      left  <= CW'(W);
      mc_q  <= mcand;
      mp_sr <= mplier;
      st    <= S_STEP;
    end else begin
      prod  <= {sum, prod[W-1:1]};
      mp_sr <= mp_sr >> 1;
      left  <= left - 1'b1;
      if (left == CW'(1)) st <= S_IDLE;
    end
  end
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
  parameter int W = 8,
  parameter int CW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic           done,
  input logic [2*W-1:0] prod,
  input logic [2:0]     st,
  input logic [CW-1:0]  left
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st) == 1);

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> done);

  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    (done && go) |=> !done);

  a_r3_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    st[0] |-> (left != '0));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |=> (prod == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(prod));
endmodule

bind shift_add_mult shift_add_mult_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .done(done),
  .prod(prod), .st(st), .left(left)
);

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           go = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           done;
  logic [2*W-1:0] prod;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  shift_add_mult #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .mcand(mcand),
    .mplier(mplier), .done(done), .prod(prod)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R3 watchdog expired act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit hold);
    longint e;
    @(negedge clk);
    mcand = W'(a); mplier = W'(b); go = 1'b1;
    chk(done == 1'b1, "R2 idle before start", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R3 done low after start", done, 0);
    if (!hold) go = 1'b0;
    @(negedge clk);
    chk(prod == '0, "R4 cleared", prod, 0);
    chk(done == 1'b0, "R3 busy", done, 0);
    mcand = ~W'(a); mplier = W'(a) ^ W'(b) ^ W'(8'h5a);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      e = longint'(a) * longint'(b % (1 << k)) * longint'(1 << (W - k));
      if (k < W) begin
        chk(done == 1'b0, hold ? "R8 R3 busy" : "R3 busy", done, 0);
        chk(prod == (2*W)'(e), "R5 partial product", prod, e);
      end else begin
        chk(done == 1'b1, hold ? "R8 R3 done rise" : "R3 done rise", done, 1);
        chk(prod == (2*W)'(a * b), hold ? "R8 R6 R7 product" : "R6 R7 product",
            prod, a * b);
        go = 1'b0;
      end
    end
  endtask

  task automatic idle_test(input int n);
    logic [2*W-1:0] keep;
    keep = prod;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mcand = W'($urandom); mplier = W'($urandom);
      chk(done == 1'b1, "R9 R2 idle done", done, 1);
      chk(prod == keep, "R9 prod held", prod, keep);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R1 done in reset", done, 1);
    chk(prod == '0, "R1 prod in reset", prod, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b1, "R1 done after reset", done, 1);
    chk(prod == '0, "R1 prod after reset", prod, 0);
    idle_test(3);
    run_op(255, 255, 1'b0);
    idle_test(4);
    run_op(0, 0, 1'b0);
    run_op(1, 255, 1'b0);
    run_op(255, 1, 1'b0);
    run_op(0, 200, 1'b0);
    run_op(200, 0, 1'b0);
    run_op(128, 128, 1'b0);
    run_op(170, 85, 1'b0);
    run_op(85, 170, 1'b0);
    run_op(200, 199, 1'b1);
    run_op(255, 255, 1'b1);
    idle_test(3);
    for (int i = 0; i < 60; i++) begin
      run_op(int'($urandom % 256), int'($urandom % 256), bit'(i % 5 == 0));
    end
    idle_test(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule